// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that follows a chain of descriptors kept in memory. Software writes the address of the first descriptor into the link-pointer register and then sets the run bit. The channel reads the four words of that descriptor over a word-wide memory master port. It then copies whole 32-bit words from a source address to a target address, and finally moves on to the descriptor named in the link word. The channel stops when it reaches a descriptor marked final, when software clears the run bit, or when the memory returns an error response.

A descriptor occupies four consecutive words: link address, source address, target address, then a command word. In the command word, bits 15:0 hold the byte count and bits 18:16 hold the flags. The channel re-reads every descriptor from memory each time it reaches it. A copy made by one descriptor can therefore rewrite the source, target and command of a later descriptor, and the channel acts on those new values. Descriptors without the flow-through flag are paced by a peripheral request line, one rising edge per word.

Top module: `dma_chain_channel`

## Requirements
- R1: After synchronous reset the memory request is idle, `stat_busy` is 0, and the done, stopped and error flags are all 0.
- R2: A descriptor at address P is read as four word reads at P, P+4, P+8 and P+12, in that order, before any data access for it. The words are link, source, target, then command.
- R3: Writing the link pointer alone (`reg_sel`=0) starts nothing. A control write (`reg_sel`=1) with bit 0 set starts the channel from the stored pointer.
- R4: Each word moved is a read from the source followed by a write to the target. The source address advances by 4 per word. A byte count n moves ceil(n/4) words, so a count of 0 moves no data and goes straight to the next descriptor without waiting for a request.
- R5: Command bit 16 set makes the target address advance by 4 per word. When bit 16 is clear, every word goes to the same target address.
- R6: With command bit 17 (flow-through) set, all words move without waiting. With bit 17 clear, each word waits for its own 0-to-1 transition of `periph_req`, and a level held high counts only once.
- R7: When a descriptor without bit 18 completes, the next descriptor is fetched from its link address. A two-entry ring that links back on itself keeps running.
- R8: Descriptor words are always read from memory at fetch time, so words written by an earlier copy into a later descriptor take effect.
- R9: When a descriptor with command bit 18 (final) completes, the channel goes idle with `stat_done` set and the run bit cleared.
- R10: Clearing the run bit stops the channel at the next word or descriptor boundary. It sets `stat_stopped`, and no further memory requests follow. At most one of done, stopped and error is set.
- R11: An error response to any access ends the channel. `stat_error` is set and `stat_busy` drops in the next cycle.
- R12: The memory port holds at most one access outstanding. A request held while `mem_req_ready` is low keeps its address, direction and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: link pointer, 1: control (bit 0 = run) |
| reg_wdata | input | 32 | Register write data |
| periph_req | input | 1 | Peripheral request line, rising edges pace words |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response strobe, one per accepted request |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Error flag qualified by mem_rsp_valid |
| stat_busy | output | 1 | Channel active |
| stat_done | output | 1 | Chain ended on a final descriptor |
| stat_stopped | output | 1 | Halted by clearing the run bit |
| stat_error | output | 1 | Halted by an error response |

## Verification
The assertions assume that the memory returns exactly one response per accepted request, and never in the same cycle the request is accepted. The single-outstanding and error-reaction properties depend on this. The bench memory keeps to these rules: it records an accepted access and answers it one cycle later. Meanwhile `mem_req_ready` follows a repeating stall pattern, so requests are held for a cycle at varied points. Request pulses are driven only at negative clock edges and last several cycles, so each intended edge is seen exactly once.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_BEAT_CHK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_NEXT
  } chan_state_e;

  // command word flag positions (byte count sits in the low half)
  localparam int FLAG_TINC   = 16;
  localparam int FLAG_FLOW   = 17;
  localparam int FLAG_FINAL  = 18;
  localparam int WORD_BYTES  = 4;
  localparam int DESC_WORDS  = 4;
endpackage

// File: rtl/dma_req_pacer.sv
module dma_req_pacer (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic req_in,
  input  logic consume,
  output logic pend
);
  logic req_q;
  logic rise;

  assign rise = req_in & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_q <= req_in;
      if (clear)        pend <= 1'b0;
      else if (rise)    pend <= 1'b1;
      else if (consume) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [1:0]        load_idx,
  input  logic [31:0]       load_word,
  input  logic              step_en,
  output logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              tgt_inc,
  output logic              flow_thru,
  output logic              final_desc,
  output logic              no_bytes
);
  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  assign no_bytes = (bytes_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_addr  <= '0;
      src_addr   <= '0;
      tgt_addr   <= '0;
      bytes_left <= '0;
      tgt_inc    <= 1'b0;
      flow_thru  <= 1'b0;
      final_desc <= 1'b0;
    end else if (load_en) begin
      case (load_idx)
        2'd0: link_addr <= load_word[ADDR_W-1:0];
        2'd1: src_addr  <= load_word[ADDR_W-1:0];
        2'd2: tgt_addr  <= load_word[ADDR_W-1:0];
        default: begin
          bytes_left <= load_word[LEN_W-1:0];
          tgt_inc    <= load_word[FLAG_TINC];
          flow_thru  <= load_word[FLAG_FLOW];
          final_desc <= load_word[FLAG_FINAL];
        end
      endcase
    end else if (step_en) begin
      src_addr <= src_addr + ADDR_STEP;
      if (tgt_inc) tgt_addr <= tgt_addr + ADDR_STEP;
      bytes_left <= (bytes_left <= LEN_STEP) ? '0 : bytes_left - LEN_STEP;
    end
  end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              periph_req,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_stopped,
  output logic              stat_error
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  chan_state_e       st;
  logic              run_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  fidx;
  logic [IDX_W-1:0]  nidx;
  logic [ADDR_W-1:0] fetch_next;

  logic              pend;
  logic              consume;
  logic              load_en;
  logic              step_en;
  logic [ADDR_W-1:0] link_addr, src_addr, tgt_addr;
  logic [LEN_W-1:0]  bytes_left;
  logic              tgt_inc, flow_thru, final_desc, no_bytes;
  logic              rsp_ok, rsp_bad;

  assign nidx       = fidx + IDX_W'(1);
  assign fetch_next = ptr_q + {{(ADDR_W-IDX_W-2){1'b0}}, nidx, 2'b00};
  assign rsp_ok     = mem_rsp_valid & ~mem_rsp_err;
  assign rsp_bad    = mem_rsp_valid &  mem_rsp_err;
  assign consume    = (st == ST_BEAT_CHK) & run_q & ~no_bytes & ~flow_thru & pend;
  assign load_en    = (st == ST_FETCH_WAIT) & rsp_ok;
  assign step_en    = (st == ST_WR_WAIT) & rsp_ok;

  dma_req_pacer u_pacer (
    .clk     (clk),
    .rst     (rst),
    .clear   (st == ST_IDLE),
    .req_in  (periph_req),
    .consume (consume),
    .pend    (pend)
  );

  dma_desc_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_idx   (fidx),
    .load_word  (mem_rsp_rdata),
    .step_en    (step_en),
    .link_addr  (link_addr),
    .src_addr   (src_addr),
    .tgt_addr   (tgt_addr),
    .bytes_left (bytes_left),
    .tgt_inc    (tgt_inc),
    .flow_thru  (flow_thru),
    .final_desc (final_desc),
    .no_bytes   (no_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      run_q         <= 1'b0;
      ptr_q         <= '0;
      fidx          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      stat_busy     <= 1'b0;
      stat_done     <= 1'b0;
      stat_stopped  <= 1'b0;
      stat_error    <= 1'b0;
    end else begin
      if (reg_we && reg_sel) run_q <= reg_wdata[0];
      if (reg_we && !reg_sel && st == ST_IDLE) ptr_q <= reg_wdata[ADDR_W-1:0];

      case (st)
        ST_IDLE: begin
          if (run_q) begin
            stat_busy     <= 1'b1;
            stat_done     <= 1'b0;
            stat_stopped  <= 1'b0;
            stat_error    <= 1'b0;
            fidx          <= '0;
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= ptr_q;
            st            <= ST_FETCH_REQ;
          end
        end
        ST_FETCH_REQ, ST_RD_REQ, ST_WR_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st <= (st == ST_FETCH_REQ) ? ST_FETCH_WAIT :
                  (st == ST_RD_REQ)    ? ST_RD_WAIT : ST_WR_WAIT;
          end
        end
        ST_FETCH_WAIT: begin
          if (rsp_ok) begin
            if (fidx == IDX_W'(DESC_WORDS - 1)) begin
              st <= ST_BEAT_CHK;
            end else begin
              fidx          <= nidx;
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b0;
              mem_req_addr  <= fetch_next;
              st            <= ST_FETCH_REQ;
            end
          end
        end
        ST_BEAT_CHK: begin
          if (!run_q) begin
            stat_busy    <= 1'b0;
            stat_stopped <= 1'b1;
            st           <= ST_IDLE;
          end else if (no_bytes) begin
            st <= ST_NEXT;
          end else if (flow_thru || pend) begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= src_addr;
            st            <= ST_RD_REQ;
          end
        end
        ST_RD_WAIT: begin
          if (rsp_ok) begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b1;
            mem_req_addr  <= tgt_addr;
            mem_req_wdata <= mem_rsp_rdata;
            st            <= ST_WR_REQ;
          end
        end
        ST_WR_WAIT: begin
          if (rsp_ok) st <= ST_BEAT_CHK;
        end
        ST_NEXT: begin
          if (final_desc) begin
            stat_busy <= 1'b0;
            stat_done <= 1'b1;
            run_q     <= 1'b0;
            st        <= ST_IDLE;
          end else if (!run_q) begin
            stat_busy    <= 1'b0;
            stat_stopped <= 1'b1;
            st           <= ST_IDLE;
          end else begin
            ptr_q         <= link_addr;
            fidx          <= '0;
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= link_addr;
            st            <= ST_FETCH_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase

      // an error response ends the chain from any waiting state
      if (rsp_bad && (st == ST_FETCH_WAIT || st == ST_RD_WAIT || st == ST_WR_WAIT)) begin
        mem_req_valid <= 1'b0;
        stat_busy     <= 1'b0;
        stat_error    <= 1'b1;
        run_q         <= 1'b0;
        st            <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/dma_chain_channel_chk.sv
module dma_chain_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              stat_busy,
  input logic              stat_done,
  input logic              stat_stopped,
  input logic              stat_error
);
  logic outs;

  always_ff @(posedge clk) begin
    if (rst)                                outs <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outs <= 1'b1;
    else if (mem_rsp_valid)                 outs <= 1'b0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && !stat_busy && !stat_done && !stat_stopped && !stat_error));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R12
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    outs |-> !mem_req_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stat_done |-> !stat_busy);

  // R11
  err_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_busy && mem_rsp_valid && mem_rsp_err) |=> (stat_error && !stat_busy));

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_done, stat_stopped, stat_error}));

  // R10
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_busy |-> !mem_req_valid);
endmodule

bind dma_chain_channel dma_chain_channel_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chain_channel_tb.sv
module dma_chain_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] F_TINC  = 32'h0001_0000;
  localparam logic [31:0] F_FLOW  = 32'h0002_0000;
  localparam logic [31:0] F_FINAL = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic periph_req = 1'b0;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic stat_busy, stat_done, stat_stopped, stat_error;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_channel #(.ADDR_W(AW), .LEN_W(16)) u_dut (.*);

  // memory model: 256 words, answers one cycle after acceptance
  logic [31:0] mem [0:255];
  logic [1:0]  rdy_cnt = '0;
  logic        pend_q = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_data = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          wr_count = 0, acc_n = 0;
  logic [31:0] acc_addr [0:1023];
  logic        acc_wr   [0:1023];

  assign mem_req_ready = (rdy_cnt != 2'd2);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      if (pend_q) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pend_data;
        mem_rsp_err   <= pend_err;
        pend_q        <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend_q    <= 1'b1;
        pend_err  <= err_en && (mem_req_addr == err_addr);
        pend_data <= mem[mem_req_addr[9:2]];
        if (acc_n < 1024) begin
          acc_addr[acc_n] <= mem_req_addr;
          acc_wr[acc_n]   <= mem_req_write;
        end
        acc_n <= acc_n + 1;
        if (mem_req_write && !(err_en && mem_req_addr == err_addr)) begin
          mem[mem_req_addr[9:2]] = mem_req_wdata;
          wr_count <= wr_count + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int wi, input logic [31:0] lnk, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] cmd);
    mem[wi] = lnk; mem[wi+1] = s; mem[wi+2] = t; mem[wi+3] = cmd;
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic start_ch(input logic [31:0] p);
    wr_reg(1'b0, p);
    wr_reg(1'b1, 32'd1);
  endtask

  task automatic wait_idle();
    int t = 0;
    repeat (3) @(negedge clk);
    while (stat_busy && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic pulse_req(input int hi);
    @(negedge clk); periph_req = 1'b1;
    repeat (hi) @(negedge clk);
    periph_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base, wc0, nw, t;
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req_valid, "R1 req idle", 32'(mem_req_valid), 0);
    chk(!stat_busy, "R1 busy", 32'(stat_busy), 0);
    chk({stat_done, stat_stopped, stat_error} == 3'b000, "R1 status",
        32'({stat_done, stat_stopped, stat_error}), 0);

    // R3 pointer write alone starts nothing
    put_desc(0, 32'h3F0, 32'h100, 32'h200, F_FINAL | F_FLOW | 32'd4);
    base = acc_n;
    wr_reg(1'b0, 32'h0);
    repeat (10) @(negedge clk);
    chk(!stat_busy && acc_n == base, "R3 no start", 32'(acc_n - base), 0);
    wr_reg(1'b1, 32'd1);
    @(negedge clk);
    chk(stat_busy, "R3 run starts", 32'(stat_busy), 1);
    wait_idle();

    // R2 R4 R5 R9 sweep over byte count and target step
    for (int len = 0; len < 14; len++) begin
      for (int ti = 0; ti < 2; ti++) begin
        put_desc(0, 32'h3F0, 32'h100, 32'h200,
                 F_FINAL | F_FLOW | (ti ? F_TINC : 32'h0) | 32'(len));
        for (int k = 0; k < 5; k++) begin
          mem[64+k]  = 32'hA000_0000 + 32'(len*256 + ti*16 + k);
          mem[128+k] = '0;
        end
        nw = (len + 3) / 4;
        base = acc_n; wc0 = wr_count;
        start_ch(32'h0);
        wait_idle();
        chk(stat_done && !stat_error && !stat_stopped && !stat_busy, "R9 done",
            32'({stat_done, stat_stopped, stat_error}), 32'b100);
        chk(wr_count - wc0 == nw, "R4 word count", 32'(wr_count - wc0), 32'(nw));
        ok = 1;
        for (int k = 0; k < 4; k++)
          if (acc_addr[base+k] != 32'(4*k) || acc_wr[base+k]) ok = 0;
        chk(ok, "R2 fetch order", acc_addr[base+3], 32'hC);
        ok = 1;
        for (int k = 0; k < nw; k++) begin
          if (acc_addr[base+4+2*k] != 32'h100 + 32'(4*k) || acc_wr[base+4+2*k]) ok = 0;
          if (acc_addr[base+5+2*k] != (ti ? 32'h200 + 32'(4*k) : 32'h200) || !acc_wr[base+5+2*k]) ok = 0;
        end
        chk(ok, "R4 R5 address stepping", 32'(len), 32'(ti));
        if (ti) begin
          ok = 1;
          for (int k = 0; k < nw; k++) if (mem[128+k] != mem[64+k]) ok = 0;
          chk(ok && mem[128+nw] == 0, "R5 incrementing target", mem[128+nw], 0);
        end else begin
          chk(mem[128] == (nw > 0 ? mem[64+nw-1] : 32'h0) && mem[129] == 0,
              "R5 fixed target", mem[128], (nw > 0 ? mem[64+nw-1] : 32'h0));
        end
      end
    end

    // R6 request pacing, one edge per word
    put_desc(0, 32'h3F0, 32'h100, 32'h200, F_FINAL | F_TINC | 32'd12);
    wc0 = wr_count;
    start_ch(32'h0);
    repeat (30) @(negedge clk);
    chk(wr_count == wc0 && stat_busy, "R6 waits for edge", 32'(wr_count - wc0), 0);
    pulse_req(12);
    repeat (20) @(negedge clk);
    chk(wr_count - wc0 == 1, "R6 held level counts once", 32'(wr_count - wc0), 1);
    pulse_req(2);
    repeat (20) @(negedge clk);
    chk(wr_count - wc0 == 2, "R6 second edge", 32'(wr_count - wc0), 2);
    pulse_req(2);
    wait_idle();
    chk(wr_count - wc0 == 3 && stat_done, "R6 paced block done", 32'(wr_count - wc0), 3);

    // R4 zero-length paced descriptor does not wait, R7 chain to next
    put_desc(0, 32'h040, 32'h100, 32'h200, 32'd0);
    put_desc(16, 32'h3F0, 32'h100, 32'h200, F_FINAL | F_FLOW | 32'd4);
    wc0 = wr_count;
    start_ch(32'h0);
    wait_idle();
    chk(stat_done && wr_count - wc0 == 1, "R4 zero length skips", 32'(wr_count - wc0), 1);

    // R8 self-modifying chain
    put_desc(0, 32'h010, 32'h0C0, 32'h014, F_FLOW | F_TINC | 32'd12);
    put_desc(4, 32'h020, 32'h0, 32'h0, 32'h0);
    mem[48] = 32'h140; mem[49] = 32'h280; mem[50] = F_FLOW | F_TINC | F_FINAL | 32'd8;
    mem[80] = 32'hCAFE_0001; mem[81] = 32'hCAFE_0002;
    mem[160] = '0; mem[161] = '0;
    wc0 = wr_count;
    start_ch(32'h0);
    wait_idle();
    chk(stat_done && wr_count - wc0 == 5, "R8 rewritten descriptor used", 32'(wr_count - wc0), 5);
    chk(mem[160] == 32'hCAFE_0001 && mem[161] == 32'hCAFE_0002, "R8 rewritten target data",
        mem[161], 32'hCAFE_0002);

    // R7 two-entry ring, R10 stop by clearing run
    put_desc(0, 32'h010, 32'h100, 32'h200, F_FLOW | F_TINC | 32'd8);
    put_desc(4, 32'h000, 32'h108, 32'h208, F_FLOW | 32'd4);
    wc0 = wr_count;
    start_ch(32'h0);
    repeat (400) @(negedge clk);
    chk(stat_busy && wr_count - wc0 >= 9, "R7 ring keeps running", 32'(wr_count - wc0), 9);
    wr_reg(1'b1, 32'd0);
    t = 0;
    while (stat_busy && t < 60) begin @(negedge clk); t++; end
    chk(stat_stopped && !stat_done && !stat_error && !stat_busy, "R10 stopped status",
        32'({stat_done, stat_stopped, stat_error}), 32'b010);
    wc0 = wr_count; base = acc_n;
    repeat (20) @(negedge clk);
    chk(wr_count == wc0 && acc_n == base, "R10 silent after stop", 32'(acc_n - base), 0);

    // R10 stop while waiting for a request
    put_desc(0, 32'h3F0, 32'h100, 32'h200, F_FINAL | 32'd8);
    wc0 = wr_count;
    start_ch(32'h0);
    repeat (30) @(negedge clk);
    wr_reg(1'b1, 32'd0);
    repeat (4) @(negedge clk);
    chk(stat_stopped && !stat_busy && wr_count == wc0, "R10 stop during wait",
        32'(wr_count - wc0), 0);

    // R11 error response on second source read
    put_desc(0, 32'h3F0, 32'h100, 32'h200, F_FINAL | F_FLOW | F_TINC | 32'd8);
    err_en = 1'b1; err_addr = 32'h104;
    wc0 = wr_count;
    start_ch(32'h0);
    wait_idle();
    chk(stat_error && !stat_done && !stat_stopped, "R11 error status",
        32'({stat_done, stat_stopped, stat_error}), 32'b001);
    chk(wr_count - wc0 == 1, "R11 halted after error", 32'(wr_count - wc0), 1);
    err_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule